// File: doc/BRIEF.md
# Synchronized Conversion Handshake Controller

This block sits beside the request arbiter of a converter sequencer that acts as master in a paired setup. Each accepted arbitration winner arrives as a valid/ready transfer carrying a channel number and the conversion attributes: resolution, external multiplexer code and input group select. The block looks up that channel's two-bit synchronization mode. A plain mode produces a one-cycle start pulse for an ordinary conversion. A synchronized mode raises a request toward the paired slave sequencer and forwards the attributes with it, together with a flag that names the flavour.

While a synchronized conversion is running, the block keeps sticky completion flags for its own side and for the slave. It releases the forwarded request once the slave reports completion. It returns to idle when both sides have finished. When the slave requests a synchronization for the same channel in the cycle the master accepts its winner, a collision pulse is raised. In cancel-sync-repeat flavour, a conversion that the slave aborts is remembered and reported for reissue once the synchronized pair has finished.

The winner port follows valid/ready rules. A transfer happens on a rising clock edge when `win_valid` and `win_ready` are both high. `win_ready` is low for the whole time a synchronized conversion is open, so the arbiter must hold its winner until it is taken. Completion, abort and peer-request inputs are plain single-cycle strobes.

Top module: `sync_hs_ctrl`

## Requirements
- R1: After reset, `win_ready` is 1. All other outputs are 0: `sy_req`, the forwarded fields, `sy_csr`, `is_master`, `mst_fin`, `slv_fin`, `conv_go`, `collide` and `resume_valid`.
- R2: Channel c's mode is the bit pair `mode_cfg[2c+1:2c]`. An accepted winner whose mode is 01 (sync-wait) or 10 (cancel-sync-repeat) gives, one cycle later, `sy_req`=1 and `is_master`=1. In that cycle `sy_ch`, `sy_res`, `sy_emux` and `sy_grp` equal the winner's fields, and `sy_csr` is 1 exactly when the mode is 10.
- R3: An accepted winner whose mode is 00 or 11 gives a one-cycle `conv_go` pulse in the next cycle. It raises no slave request, and `win_ready` stays 1.
- R4: While `is_master` is 1, `win_ready` is 0. Winners presented in that time are not taken and change no output.
- R5: `sy_req` and every forwarded field hold their values until `slave_done` is seen. All of them read 0 in the cycle after the cycle where `slave_done` is high.
- R6: `mst_fin` becomes 1 in the cycle after `own_done` and `slv_fin` becomes 1 in the cycle after `slave_done`, both during an open synchronized conversion. Each stays 1 until the conversion closes.
- R7: When both sides have finished, counting strobes that arrive in the current cycle, the next cycle shows `is_master`=0, `mst_fin`=0, `slv_fin`=0 and `win_ready`=1.
- R8: `collide` pulses for one cycle, one cycle after a synchronized winner is accepted while `peer_req` is high with `peer_ch` equal to `win_ch`. It does not pulse for a different channel or for a plain-mode winner.
- R9: In cancel-sync-repeat flavour, a `slv_abort` during the open conversion is held pending. `resume_valid` pulses with `resume_ch` set to the channel of the latest abort, in the same cycle the block returns to idle. In sync-wait flavour, aborts produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | 1 | Arbitration winner present |
| win_ready | output | 1 | Block can take a winner |
| win_ch | input | CH_W (3) | Winning channel |
| win_res | input | RES_W (2) | Resolution of the winner |
| win_emux | input | EMUX_W (3) | External multiplexer code of the winner |
| win_grp | input | GRP_W (1) | Input group select of the winner |
| mode_cfg | input | 2*NCH (16) | Two-bit synchronization mode per channel |
| conv_go | output | 1 | Start pulse for an unsynchronized conversion |
| sy_req | output | 1 | Synchronized request into the slave |
| sy_ch | output | CH_W (3) | Channel forwarded to the slave |
| sy_res | output | RES_W (2) | Resolution forwarded to the slave |
| sy_emux | output | EMUX_W (3) | Multiplexer code forwarded to the slave |
| sy_grp | output | GRP_W (1) | Group select forwarded to the slave |
| sy_csr | output | 1 | 1 = cancel-sync-repeat, 0 = sync-wait |
| is_master | output | 1 | Master role active in a synchronized conversion |
| own_done | input | 1 | Master's own conversion finished (strobe) |
| slave_done | input | 1 | Slave's conversion finished (strobe) |
| mst_fin | output | 1 | Sticky master-finished flag |
| slv_fin | output | 1 | Sticky slave-finished flag |
| peer_req | input | 1 | Slave requests a synchronization this cycle |
| peer_ch | input | CH_W (3) | Channel of the slave's request |
| collide | output | 1 | Same-cycle same-channel request pulse |
| slv_abort | input | 1 | Slave aborted a conversion (strobe) |
| abort_ch | input | CH_W (3) | Channel of the aborted conversion |
| resume_valid | output | 1 | Aborted slave conversion is due for reissue |
| resume_ch | output | CH_W (3) | Channel to reissue |

## Verification
The properties assume that completion and abort strobes matter only while a synchronized conversion is open, and that `mode_cfg` does not change in the cycle a winner is accepted. The random stimulus re-rolls the mode table only between phases and never inside a cycle. The strobes arrive at random and often in the same cycle or outside an open conversion. The checks therefore cover the rule that idle strobes are ignored. Directed cases add a same-channel collision, a near-miss collision on another channel, the reserved mode 11, and an abort that lands in the same cycle as the final completion.

// File: rtl/sync_hs_pkg.sv
package sync_hs_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_WAIT  = 2'b01,
    MODE_CSR   = 2'b10,
    MODE_RSVD  = 2'b11
  } sync_mode_e;

  function automatic logic mode_is_sync(input sync_mode_e m);
    return (m == MODE_WAIT) || (m == MODE_CSR);
  endfunction

endpackage

// File: rtl/sync_mode_sel.sv
module sync_mode_sel
  import sync_hs_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic [2*NCH-1:0] cfg,
  input  logic [CH_W-1:0]  ch,
  output sync_mode_e       mode
);

  sync_mode_e tbl [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_tbl
    assign tbl[g] = sync_mode_e'(cfg[2*g +: 2]);
  end

  always_comb begin
    if (int'(ch) < NCH) mode = tbl[ch];
    else                mode = MODE_PLAIN;
  end

endmodule

// File: rtl/sync_fwd_reg.sv
module sync_fwd_reg #(
  parameter int CH_W   = 3,
  parameter int RES_W  = 2,
  parameter int EMUX_W = 3,
  parameter int GRP_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [CH_W-1:0]   ch_in,
  input  logic [RES_W-1:0]  res_in,
  input  logic [EMUX_W-1:0] emux_in,
  input  logic [GRP_W-1:0]  grp_in,
  input  logic              csr_in,
  output logic              req,
  output logic [CH_W-1:0]   ch,
  output logic [RES_W-1:0]  res,
  output logic [EMUX_W-1:0] emux,
  output logic [GRP_W-1:0]  grp,
  output logic              csr
);

  always_ff @(posedge clk) begin
    if (!rst_n || (clear && !load)) begin
      req  <= 1'b0;
      ch   <= '0;
      res  <= '0;
      emux <= '0;
      grp  <= '0;
      csr  <= 1'b0;
    end else if (load) begin
      req  <= 1'b1;
      ch   <= ch_in;
      res  <= res_in;
      emux <= emux_in;
      grp  <= grp_in;
      csr  <= csr_in;
    end
  end

endmodule

// File: rtl/sync_done_track.sv
module sync_done_track (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic active,
  input  logic own_done,
  input  logic peer_done,
  output logic mst_fin,
  output logic slv_fin,
  output logic both_done
);

  logic mst_nxt, slv_nxt;

  always_comb begin
    mst_nxt   = mst_fin | own_done;
    slv_nxt   = slv_fin | peer_done;
    both_done = active && mst_nxt && slv_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || arm || both_done) begin
      mst_fin <= 1'b0;
      slv_fin <= 1'b0;
    end else if (active) begin
      mst_fin <= mst_nxt;
      slv_fin <= slv_nxt;
    end
  end

endmodule

// File: rtl/sync_resume_keep.sv
module sync_resume_keep #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            csr_in,
  input  logic            active,
  input  logic            finish,
  input  logic            abort,
  input  logic [CH_W-1:0] abort_ch,
  output logic            resume_valid,
  output logic [CH_W-1:0] resume_ch
);

  logic            csr_q;
  logic            pend_q;
  logic [CH_W-1:0] pend_ch_q;
  logic            take_abort;

  assign take_abort = active && csr_q && abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q        <= 1'b0;
      pend_q       <= 1'b0;
      pend_ch_q    <= '0;
      resume_valid <= 1'b0;
      resume_ch    <= '0;
    end else begin
      resume_valid <= 1'b0;
      if (arm) begin
        csr_q  <= csr_in;
        pend_q <= 1'b0;
      end else if (active && finish) begin
        if (pend_q || take_abort) begin
          resume_valid <= 1'b1;
          resume_ch    <= take_abort ? abort_ch : pend_ch_q;
        end
        pend_q <= 1'b0;
      end else if (take_abort) begin
        pend_q    <= 1'b1;
        pend_ch_q <= abort_ch;
      end
    end
  end

endmodule

// File: rtl/sync_hs_ctrl.sv
module sync_hs_ctrl
  import sync_hs_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int RES_W  = 2,
  parameter int EMUX_W = 3,
  parameter int GRP_W  = 1,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_valid,
  output logic              win_ready,
  input  logic [CH_W-1:0]   win_ch,
  input  logic [RES_W-1:0]  win_res,
  input  logic [EMUX_W-1:0] win_emux,
  input  logic [GRP_W-1:0]  win_grp,
  input  logic [2*NCH-1:0]  mode_cfg,
  output logic              conv_go,
  output logic              sy_req,
  output logic [CH_W-1:0]   sy_ch,
  output logic [RES_W-1:0]  sy_res,
  output logic [EMUX_W-1:0] sy_emux,
  output logic [GRP_W-1:0]  sy_grp,
  output logic              sy_csr,
  output logic              is_master,
  input  logic              own_done,
  input  logic              slave_done,
  output logic              mst_fin,
  output logic              slv_fin,
  input  logic              peer_req,
  input  logic [CH_W-1:0]   peer_ch,
  output logic              collide,
  input  logic              slv_abort,
  input  logic [CH_W-1:0]   abort_ch,
  output logic              resume_valid,
  output logic [CH_W-1:0]   resume_ch
);

  sync_mode_e win_mode;
  logic       busy_q;
  logic       accept, synced, arm, both_done;

  sync_mode_sel #(.NCH(NCH), .CH_W(CH_W)) u_sel (
    .cfg  (mode_cfg),
    .ch   (win_ch),
    .mode (win_mode)
  );

  assign win_ready = !busy_q;
  assign is_master = busy_q;
  assign accept    = win_valid && !busy_q;
  assign synced    = mode_is_sync(win_mode);
  assign arm       = accept && synced;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      conv_go <= 1'b0;
      collide <= 1'b0;
    end else begin
      conv_go <= accept && !synced;
      collide <= arm && peer_req && (peer_ch == win_ch);
      if (arm)            busy_q <= 1'b1;
      else if (both_done) busy_q <= 1'b0;
    end
  end

  sync_fwd_reg #(.CH_W(CH_W), .RES_W(RES_W), .EMUX_W(EMUX_W), .GRP_W(GRP_W)) u_fwd (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (arm),
    .clear   (busy_q && slave_done),
    .ch_in   (win_ch),
    .res_in  (win_res),
    .emux_in (win_emux),
    .grp_in  (win_grp),
    .csr_in  (win_mode == MODE_CSR),
    .req     (sy_req),
    .ch      (sy_ch),
    .res     (sy_res),
    .emux    (sy_emux),
    .grp     (sy_grp),
    .csr     (sy_csr)
  );

  sync_done_track u_done (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .active    (busy_q),
    .own_done  (own_done),
    .peer_done (slave_done),
    .mst_fin   (mst_fin),
    .slv_fin   (slv_fin),
    .both_done (both_done)
  );

  sync_resume_keep #(.CH_W(CH_W)) u_keep (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm          (arm),
    .csr_in       (win_mode == MODE_CSR),
    .active       (busy_q),
    .finish       (both_done),
    .abort        (slv_abort),
    .abort_ch     (abort_ch),
    .resume_valid (resume_valid),
    .resume_ch    (resume_ch)
  );

endmodule

// File: rtl/sync_hs_chk.sv
module sync_hs_chk #(
  parameter int NCH    = 8,
  parameter int RES_W  = 2,
  parameter int EMUX_W = 3,
  parameter int GRP_W  = 1,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              win_valid,
  input logic              win_ready,
  input logic [CH_W-1:0]   win_ch,
  input logic [2*NCH-1:0]  mode_cfg,
  input logic              conv_go,
  input logic              sy_req,
  input logic [CH_W-1:0]   sy_ch,
  input logic [RES_W-1:0]  sy_res,
  input logic [EMUX_W-1:0] sy_emux,
  input logic [GRP_W-1:0]  sy_grp,
  input logic              sy_csr,
  input logic              is_master,
  input logic              own_done,
  input logic              slave_done,
  input logic              mst_fin,
  input logic              slv_fin,
  input logic              peer_req,
  input logic              collide,
  input logic              resume_valid
);

  logic [1:0] cur_mode;
  logic       cur_sync, take;

  assign cur_mode = mode_cfg[{win_ch, 1'b0} +: 2];
  assign cur_sync = (cur_mode == 2'b01) || (cur_mode == 2'b10);
  assign take     = win_valid && win_ready;

  AST_SYNC_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cur_sync) |=> (sy_req && is_master && sy_ch == $past(win_ch))); // R2
  AST_PLAIN_START: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cur_sync) |=> (conv_go && !sy_req && win_ready)); // R3
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> !win_ready); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sy_req && !slave_done) |=> (sy_req && $stable(sy_ch) && $stable(sy_res) && $stable(sy_emux) && $stable(sy_grp) && $stable(sy_csr))); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (sy_req && slave_done) |=> !sy_req); // R5
  AST_FIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_fin && !slv_fin && !slave_done) |=> mst_fin); // R6
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && (mst_fin || own_done) && (slv_fin || slave_done)) |=> (!is_master && !mst_fin && !slv_fin)); // R7
  AST_COLLIDE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> $past(take && peer_req && cur_sync)); // R8
  AST_RESUME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |-> (win_ready && !is_master)); // R9

endmodule

bind sync_hs_ctrl sync_hs_chk #(
  .NCH(NCH), .RES_W(RES_W), .EMUX_W(EMUX_W), .GRP_W(GRP_W), .CH_W(CH_W)
) u_chk (.*);

// File: tb/tb_sync_hs_ctrl.sv
`timescale 1ns/1ps
module tb_sync_hs_ctrl;

  localparam int NCH = 8, CH_W = 3, RES_W = 2, EMUX_W = 3, GRP_W = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              win_valid = 0, own_done = 0, slave_done = 0, peer_req = 0, slv_abort = 0;
  logic [CH_W-1:0]   win_ch = 0, peer_ch = 0, abort_ch = 0;
  logic [RES_W-1:0]  win_res = 0;
  logic [EMUX_W-1:0] win_emux = 0;
  logic [GRP_W-1:0]  win_grp = 0;
  logic [2*NCH-1:0]  mode_cfg = 0;
  logic              win_ready, conv_go, sy_req, sy_csr, is_master, mst_fin, slv_fin, collide, resume_valid;
  logic [CH_W-1:0]   sy_ch, resume_ch;
  logic [RES_W-1:0]  sy_res;
  logic [EMUX_W-1:0] sy_emux;
  logic [GRP_W-1:0]  sy_grp;

  sync_hs_ctrl #(.NCH(NCH), .RES_W(RES_W), .EMUX_W(EMUX_W), .GRP_W(GRP_W)) dut (.*);

  int n_chk = 0, n_bad = 0;

  // reference state built from the requirements
  logic            m_busy = 0, m_sreq = 0, m_csr = 0, m_csrq = 0, m_mf = 0, m_sf = 0;
  logic            m_pend = 0, m_go = 0, m_col = 0, m_rv = 0;
  logic [CH_W-1:0] m_ch = 0, m_pch = 0, m_rch = 0;
  logic [RES_W-1:0]  m_res = 0;
  logic [EMUX_W-1:0] m_emux = 0;
  logic [GRP_W-1:0]  m_grp = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] mode_of(input logic [CH_W-1:0] c);
    return mode_cfg[{c, 1'b0} +: 2];
  endfunction

  task automatic model_step();
    logic [1:0] md;
    logic acc, sy, mfn, sfn, ab;
    md  = mode_of(win_ch);
    acc = win_valid && !m_busy;
    sy  = (md == 2'b01) || (md == 2'b10);
    m_go  = acc && !sy;                                        // R3
    m_col = acc && sy && peer_req && (peer_ch == win_ch);      // R8
    m_rv  = 1'b0;
    if (acc && sy) begin                                       // R2
      m_busy = 1; m_sreq = 1; m_ch = win_ch; m_res = win_res; m_emux = win_emux;
      m_grp = win_grp; m_csr = (md == 2'b10); m_csrq = m_csr; m_mf = 0; m_sf = 0; m_pend = 0;
    end else if (m_busy) begin
      mfn = m_mf | own_done;
      sfn = m_sf | slave_done;
      ab  = m_csrq && slv_abort;
      if (slave_done) begin                                    // R5
        m_sreq = 0; m_ch = 0; m_res = 0; m_emux = 0; m_grp = 0; m_csr = 0;
      end
      if (mfn && sfn) begin                                    // R7
        m_busy = 0; m_mf = 0; m_sf = 0;
        if (m_pend || ab) begin                                // R9
          m_rv = 1; m_rch = ab ? abort_ch : m_pch;
        end
        m_pend = 0;
      end else begin                                           // R6
        m_mf = mfn; m_sf = sfn;
        if (ab) begin m_pend = 1; m_pch = abort_ch; end
      end
    end
  endtask

  task automatic compare();
    chk(win_ready == !m_busy, "R4 win_ready", 32'(win_ready), 32'(!m_busy));
    chk(is_master == m_busy, "R7 is_master", 32'(is_master), 32'(m_busy));
    chk(sy_req == m_sreq, "R2 sy_req", 32'(sy_req), 32'(m_sreq));
    chk({sy_ch, sy_res, sy_emux, sy_grp, sy_csr} == {m_ch, m_res, m_emux, m_grp, m_csr},
        "R5 fwd fields", 32'({sy_ch, sy_res, sy_emux, sy_grp, sy_csr}), 32'({m_ch, m_res, m_emux, m_grp, m_csr}));
    chk({mst_fin, slv_fin} == {m_mf, m_sf}, "R6 fin flags", 32'({mst_fin, slv_fin}), 32'({m_mf, m_sf}));
    chk(conv_go == m_go, "R3 conv_go", 32'(conv_go), 32'(m_go));
    chk(collide == m_col, "R8 collide", 32'(collide), 32'(m_col));
    chk(resume_valid == m_rv, "R9 resume_valid", 32'(resume_valid), 32'(m_rv));
    if (m_rv) chk(resume_ch == m_rch, "R9 resume_ch", 32'(resume_ch), 32'(m_rch));
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    #2;
    compare();
    @(negedge clk);
  endtask

  task automatic quiet();
    win_valid = 0; own_done = 0; slave_done = 0; peer_req = 0; slv_abort = 0;
  endtask

  task automatic set_mode(input int c, input logic [1:0] m);
    mode_cfg[2*c +: 2] = m;
  endtask

  task automatic offer(input int c, input logic pr, input int pc);
    quiet();
    win_valid = 1; win_ch = CH_W'(c); win_res = 2'd3; win_emux = 3'd5; win_grp = 1'b1;
    peer_req = pr; peer_ch = CH_W'(pc);
    cyc();
    quiet();
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1: reset values
    chk({win_ready, sy_req, is_master, mst_fin, slv_fin, conv_go, collide, resume_valid} == 8'b1000_0000,
        "R1 reset outputs", 32'({win_ready, sy_req, is_master, mst_fin, slv_fin, conv_go, collide, resume_valid}), 32'h80);
    chk({sy_ch, sy_res, sy_emux, sy_grp, sy_csr} == '0, "R1 reset fields",
        32'({sy_ch, sy_res, sy_emux, sy_grp, sy_csr}), 32'h0);
    rst_n = 1;
    @(negedge clk);

    // directed: reserved mode 11 behaves as plain (R3)
    set_mode(2, 2'b11);
    offer(2, 1'b1, 2);
    // directed: sync-wait with peer on other channel, no collision (R8); abort ignored (R9)
    set_mode(4, 2'b01);
    offer(4, 1'b1, 5);
    slv_abort = 1; abort_ch = 3'd6; cyc(); quiet();
    offer(1, 1'b0, 0);                 // R4: blocked while busy
    slave_done = 1; cyc(); quiet();    // R5
    cyc();
    own_done = 1; cyc(); quiet();      // R7
    // directed: cancel-sync-repeat, same-channel collision (R8), abort in the finishing cycle (R9)
    set_mode(7, 2'b10);
    offer(7, 1'b1, 7);
    slv_abort = 1; abort_ch = 3'd3; cyc(); quiet();
    own_done = 1; slave_done = 1; slv_abort = 1; abort_ch = 3'd5; cyc(); quiet();
    cyc();

    // constrained random phases
    for (int ph = 0; ph < 6; ph++) begin
      mode_cfg = 16'($urandom);
      for (int i = 0; i < 500; i++) begin
        win_valid  = ($urandom % 2) == 0;
        win_ch     = CH_W'($urandom);
        win_res    = RES_W'($urandom);
        win_emux   = EMUX_W'($urandom);
        win_grp    = GRP_W'($urandom);
        own_done   = ($urandom % 7) == 0;
        slave_done = ($urandom % 7) == 0;
        peer_req   = ($urandom % 3) == 0;
        peer_ch    = (($urandom % 2) == 0) ? win_ch : CH_W'($urandom);
        slv_abort  = ($urandom % 10) == 0;
        abort_ch   = CH_W'($urandom);
        cyc();
      end
      quiet();
      cyc();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule